// File: doc/BRIEF.md
# Streaming Complex Multiplier With Truncation

This block multiplies a stream of complex data samples by a stream of unit-magnitude complex sinusoid samples and emits one complex product for each matched pair. It sits between a phase-to-sinusoid generator and a later rounding stage in a frequency-shift chain. The two input streams have valid/ready handshakes, and both are taken in the same cycle. The output is a valid/ready stream whose packet boundary marker comes only from the data stream.

Each data word carries two signed lanes with 15 fractional bits, and only the low 21 bits of each 24-bit lane count. Each sinusoid word carries two signed 16-bit components with 14 fractional bits. The block forms the exact 38-bit real and imaginary sums in a three-stage pipeline of plain signed multiplies. It then discards the six lowest bits, which leaves 32-bit components with 23 fractional bits. No rounding or saturation is applied here.

A small control state machine gates the handshakes and has three states:
- ST_RESET is held while `rst_n` is low.
- ST_WARM is entered on the first clock edge after release.
- ST_RUN is entered on the next edge and kept until reset.

While the controller is in ST_RESET or ST_WARM, the block accepts nothing and advances nothing. This gives the datapath at least two quiet cycles around reset.

Top module: `cplx_stream_mult`

## Requirements
- R1: The following conditions hold while `rst_n` is low and for the first two rising edges after it goes high: `a_ready`, `b_ready` and `y_valid` are all 0. From the third edge onward, the readies follow R2.
- R2: A transfer on A and B happens in one cycle, only when `a_valid`, `b_valid` and `y_ready` are all 1. `a_ready` does not depend on `a_valid`, and `b_ready` does not depend on `b_valid`. With only A valid, `a_ready`=0 and `b_ready`=1. With only B valid, `a_ready`=1 and `b_ready`=0.
- R3: The output word is {imag[31:0], real[31:0]}. real = I·cos − Q·sin and imag = I·sin + Q·cos.
- R4: In the A word, I sits in bits [20:0] and Q sits in bits [44:24], both signed. Bits [23:21] and [47:45] have no effect on any output.
- R5: In the B word, sin sits in bits [31:16] and cos sits in bits [15:0], both signed with 14 fractional bits.
- R6: Each 38-bit exact sum is shifted right by 6 with truncation toward negative infinity. For example, I = −1, Q = 0, cos = 1, sin = 0 gives real = 0xFFFFFFFF and imag = 0.
- R7: `y_last` equals the `a_last` of the pair that produced the word. `b_last` has no effect.
- R8: With `y_ready` held high, a pair accepted at a clock edge appears on the output after the third rising edge counted from that edge.
- R9: While `y_ready` is 0, both readies are 0, and a valid output word keeps its data and `y_last` unchanged.
- R10: Outputs leave in acceptance order, one per accepted pair, with none lost or added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_data | input | 48 | Data sample: Q lane upper, I lane lower |
| a_last | input | 1 | Packet boundary marker for the data sample |
| a_valid | input | 1 | Data sample offered |
| a_ready | output | 1 | Data sample taken this cycle if valid |
| b_data | input | 32 | Sinusoid sample: sin upper, cos lower |
| b_last | input | 1 | Marker on sinusoid stream (unused) |
| b_valid | input | 1 | Sinusoid sample offered |
| b_ready | output | 1 | Sinusoid sample taken this cycle if valid |
| y_data | output | 64 | Product: imag upper, real lower |
| y_last | output | 1 | Marker copied from data stream |
| y_valid | output | 1 | Product present |
| y_ready | input | 1 | Downstream can take the product |

## Verification
The assertions check several handshake rules on every cycle:
- The quiet window after reset.
- That one stream is never taken without the other.
- That no input is taken while the output is stalled.
- That a stalled output word stays frozen.

The arithmetic can only be shown by the bench scenarios, which compare each output against an independent model. These cover the lane and component placement, the floor truncation of negative results, padding and `b_last` having no effect, the three-cycle latency and order preservation. The scenarios use random and extreme operands under random backpressure.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    // Handshake controller states
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_WARM  = 2'd1,
        ST_RUN   = 2'd2
    } cmul_state_e;

endpackage

// File: rtl/cmul_ctrl.sv
module cmul_ctrl
    import cmul_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_valid,
    input  logic b_valid,
    input  logic y_ready,
    output logic a_ready,
    output logic b_ready,
    output logic fire,
    output logic adv
);

    cmul_state_e state_q;
    cmul_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: state_d = ST_WARM;
            ST_WARM:  state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_RESET;
        endcase
    end

    // Outputs: each ready looks only at the other stream's valid
    always_comb begin
        a_ready = 1'b0;
        b_ready = 1'b0;
        fire    = 1'b0;
        adv     = 1'b0;
        unique case (state_q)
            ST_RESET, ST_WARM: begin
                a_ready = 1'b0;
                b_ready = 1'b0;
            end
            ST_RUN: begin
                adv     = y_ready;
                a_ready = y_ready & b_valid;
                b_ready = y_ready & a_valid;
                fire    = y_ready & a_valid & b_valid;
            end
            default: begin
                adv = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cmul_operand_stage.sv
module cmul_operand_stage #(
    parameter int LANE_W = 24,
    parameter int SIG_W  = 21,
    parameter int SIN_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic                 fire,
    input  logic [2*LANE_W-1:0]  a_data,
    input  logic                 a_last,
    input  logic [2*SIN_W-1:0]   b_data,
    output logic [2*SIG_W-1:0]   d_q,
    output logic [2*SIN_W-1:0]   w_q,
    output logic                 last_q,
    output logic                 valid_q
);

    localparam int PAD_W = LANE_W - SIG_W;

    // One register per data lane; lane 0 = I, lane 1 = Q
    for (genvar l = 0; l < 2; l++) begin : g_lane
        logic [SIG_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (adv && fire) begin
                lane_q <= a_data[l*LANE_W +: SIG_W];
            end
        end
        assign d_q[l*SIG_W +: SIG_W] = lane_q;

        if (PAD_W > 0) begin : g_pad
            logic unused_pad;
            assign unused_pad = ^a_data[l*LANE_W+SIG_W +: PAD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (adv && fire) begin
            w_q    <= b_data;
            last_q <= a_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (adv) begin
            valid_q <= fire;
        end
    end

endmodule

// File: rtl/cmul_product_stage.sv
module cmul_product_stage #(
    parameter int SIG_W = 21,
    parameter int SIN_W = 16,
    localparam int MUL_W = SIG_W + SIN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic [2*SIG_W-1:0]   d_q,
    input  logic [2*SIN_W-1:0]   w_q,
    input  logic                 last_i,
    input  logic                 valid_i,
    output logic [4*MUL_W-1:0]   pp,
    output logic                 last_q,
    output logic                 valid_q
);

    // Partial products: 0 = I*cos, 1 = Q*sin, 2 = I*sin, 3 = Q*cos
    for (genvar g = 0; g < 4; g++) begin : g_mul
        localparam int DSEL = g % 2;
        localparam int WSEL = (g == 1 || g == 2) ? 1 : 0;
        logic signed [SIG_W-1:0] dop;
        logic signed [SIN_W-1:0] wop;
        logic signed [MUL_W-1:0] p_q;
        assign dop = d_q[DSEL*SIG_W +: SIG_W];
        assign wop = w_q[WSEL*SIN_W +: SIN_W];
        always_ff @(posedge clk) begin
            if (adv) begin
                p_q <= dop * wop;
            end
        end
        assign pp[g*MUL_W +: MUL_W] = p_q;
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            last_q <= last_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (adv) begin
            valid_q <= valid_i;
        end
    end

endmodule

// File: rtl/cmul_combine_stage.sv
module cmul_combine_stage #(
    parameter int MUL_W  = 37,
    parameter int DROP_W = 6,
    localparam int FULL_W = MUL_W + 1,
    localparam int OUT_W  = FULL_W - DROP_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic [4*MUL_W-1:0]   pp,
    input  logic                 last_i,
    input  logic                 valid_i,
    output logic [2*OUT_W-1:0]   y_data,
    output logic                 y_last,
    output logic                 y_valid
);

    logic signed [MUL_W-1:0]  p_ic, p_qs, p_is, p_qc;
    logic signed [FULL_W-1:0] re_full, im_full;

    assign p_ic = pp[0*MUL_W +: MUL_W];
    assign p_qs = pp[1*MUL_W +: MUL_W];
    assign p_is = pp[2*MUL_W +: MUL_W];
    assign p_qc = pp[3*MUL_W +: MUL_W];

    always_comb begin
        re_full = p_ic;
        re_full = re_full - p_qs;
        im_full = p_is;
        im_full = im_full + p_qc;
    end

    // Dropping low bits of a two's complement value floors it
    always_ff @(posedge clk) begin
        if (adv) begin
            y_data <= {im_full[FULL_W-1:DROP_W], re_full[FULL_W-1:DROP_W]};
            y_last <= last_i;
        end
    end

    generate
        if (DROP_W > 0) begin : g_drop
            logic unused_low;
            assign unused_low = ^{re_full[DROP_W-1:0], im_full[DROP_W-1:0]};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_valid <= 1'b0;
        end else if (adv) begin
            y_valid <= valid_i;
        end
    end

endmodule

// File: rtl/cplx_stream_mult.sv
module cplx_stream_mult #(
    parameter int LANE_W = 24,
    parameter int SIG_W  = 21,
    parameter int SIN_W  = 16,
    parameter int DROP_W = 6,
    localparam int MUL_W = SIG_W + SIN_W,
    localparam int OUT_W = MUL_W + 1 - DROP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*LANE_W-1:0] a_data,
    input  logic                a_last,
    input  logic                a_valid,
    output logic                a_ready,
    input  logic [2*SIN_W-1:0]  b_data,
    input  logic                b_last,
    input  logic                b_valid,
    output logic                b_ready,
    output logic [2*OUT_W-1:0]  y_data,
    output logic                y_last,
    output logic                y_valid,
    input  logic                y_ready
);

    logic                fire, adv;
    logic [2*SIG_W-1:0]  d_q;
    logic [2*SIN_W-1:0]  w_q;
    logic                s1_last, s1_valid;
    logic [4*MUL_W-1:0]  pp;
    logic                s2_last, s2_valid;
    logic                unused_b_last;

    assign unused_b_last = b_last;

    cmul_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_valid (a_valid),
        .b_valid (b_valid),
        .y_ready (y_ready),
        .a_ready (a_ready),
        .b_ready (b_ready),
        .fire    (fire),
        .adv     (adv)
    );

    cmul_operand_stage #(
        .LANE_W (LANE_W),
        .SIG_W  (SIG_W),
        .SIN_W  (SIN_W)
    ) u_opnd (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .fire    (fire),
        .a_data  (a_data),
        .a_last  (a_last),
        .b_data  (b_data),
        .d_q     (d_q),
        .w_q     (w_q),
        .last_q  (s1_last),
        .valid_q (s1_valid)
    );

    cmul_product_stage #(
        .SIG_W (SIG_W),
        .SIN_W (SIN_W)
    ) u_prod (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .d_q     (d_q),
        .w_q     (w_q),
        .last_i  (s1_last),
        .valid_i (s1_valid),
        .pp      (pp),
        .last_q  (s2_last),
        .valid_q (s2_valid)
    );

    cmul_combine_stage #(
        .MUL_W  (MUL_W),
        .DROP_W (DROP_W)
    ) u_comb (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .pp      (pp),
        .last_i  (s2_last),
        .valid_i (s2_valid),
        .y_data  (y_data),
        .y_last  (y_last),
        .y_valid (y_valid)
    );

endmodule

// File: rtl/cmul_checker.sv
module cmul_checker #(
    parameter int Y_W = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic           a_valid,
    input logic           a_ready,
    input logic           b_valid,
    input logic           b_ready,
    input logic [Y_W-1:0] y_data,
    input logic           y_last,
    input logic           y_valid,
    input logic           y_ready
);

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) || !$past(rst_n, 2)) |-> (!a_ready && !b_ready)); // R1

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !y_valid); // R1

    AST_A_NEEDS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_ready) |-> (b_valid && b_ready)); // R2

    AST_B_NEEDS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_ready) |-> (a_valid && a_ready)); // R2

    AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        !y_ready |-> (!a_ready && !b_ready)); // R9

    AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (y_valid && !y_ready) |=> (y_valid && $stable(y_data) && $stable(y_last))); // R9

endmodule

bind cplx_stream_mult cmul_checker #(.Y_W(2*OUT_W)) u_chk (.*);

// File: tb/sim_cplx_stream_mult.sv
`timescale 1ns/1ps
module sim_cplx_stream_mult;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] a_data = '0;
    logic        a_last = 1'b0, a_valid = 1'b0;
    logic        a_ready;
    logic [31:0] b_data = '0;
    logic        b_last = 1'b0, b_valid = 1'b0;
    logic        b_ready;
    logic [63:0] y_data;
    logic        y_last, y_valid;
    logic        y_ready = 1'b0;

    int errors = 0;
    int checks = 0;

    logic [64:0] exp_q [0:4095];
    int wp = 0;
    int rp = 0;

    always #5 clk = ~clk;

    cplx_stream_mult u0 (
        .clk(clk), .rst_n(rst_n),
        .a_data(a_data), .a_last(a_last), .a_valid(a_valid), .a_ready(a_ready),
        .b_data(b_data), .b_last(b_last), .b_valid(b_valid), .b_ready(b_ready),
        .y_data(y_data), .y_last(y_last), .y_valid(y_valid), .y_ready(y_ready)
    );

    function automatic logic [63:0] model(input logic [47:0] a, input logic [31:0] b);
        longint i, q, s, c, re, im;
        i = longint'($signed(a[20:0]));
        q = longint'($signed(a[44:24]));
        s = longint'($signed(b[31:16]));
        c = longint'($signed(b[15:0]));
        re = (i * c - q * s) >>> 6;
        im = (i * s + q * c) >>> 6;
        return {im[31:0], re[31:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, then score handshakes before the next edge
    task automatic cyc(input bit av, input bit bv, input bit yr,
                       input logic [47:0] ad, input logic [31:0] bd,
                       input bit al, input bit bl);
        @(negedge clk);
        a_valid = av; b_valid = bv; y_ready = yr;
        a_data = ad; b_data = bd; a_last = al; b_last = bl;
        #1;
        if (a_valid && a_ready && b_valid && b_ready) begin
            exp_q[wp % 4096] = {al, model(ad, bd)};
            wp++;
        end
        if (y_valid && y_ready) begin
            if (rp < wp) begin
                check({y_last, y_data} == exp_q[rp % 4096], "R3/R4/R5/R6/R7/R10 product",
                      {y_last, y_data}, exp_q[rp % 4096]);
                rp++;
            end else begin
                check(1'b0, "R10 unexpected output", {y_last, y_data}, '0);
            end
        end
    endtask

    function automatic logic [23:0] rand_lane();
        logic [23:0] v;
        v = 24'($urandom);
        case ($urandom % 8)
            0: v[20:0] = 21'h100000;
            1: v[20:0] = 21'h0FFFFF;
            2: v[20:0] = 21'h1FFFFF;
            default: ;
        endcase
        return v;
    endfunction

    function automatic logic [15:0] rand_comp();
        logic [15:0] v;
        v = 16'($urandom);
        case ($urandom % 8)
            0: v = 16'h8000;
            1: v = 16'h4000;
            2: v = 16'hC000;
            default: ;
        endcase
        return v;
    endfunction

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] held;
        logic        held_last;
        void'($urandom(32'd1234));

        // R1: reset and release window
        a_valid = 1; b_valid = 1; y_ready = 1;
        repeat (3) @(negedge clk);
        #1;
        check(!a_ready && !b_ready && !y_valid, "R1 in reset", {a_ready, b_ready, y_valid}, '0);
        @(negedge clk); rst_n = 1; #1;
        check(!a_ready && !b_ready, "R1 release", {a_ready, b_ready}, '0);
        @(negedge clk); #1;
        check(!a_ready && !b_ready && !y_valid, "R1 after edge 1", {a_ready, b_ready, y_valid}, '0);
        @(negedge clk); #1;
        check(a_ready && b_ready, "R1 ready after edge 2", {a_ready, b_ready}, 2'b11);
        a_valid = 0; b_valid = 0;

        // R2: each ready independent of its own valid
        cyc(1, 0, 1, '0, '0, 0, 0);
        check(!a_ready && b_ready, "R2 only A valid", {a_ready, b_ready}, 2'b01);
        cyc(0, 1, 1, '0, '0, 0, 0);
        check(a_ready && !b_ready, "R2 only B valid", {a_ready, b_ready}, 2'b10);
        // R9: no acceptance while output stalled
        cyc(1, 1, 0, '0, '0, 0, 0);
        check(!a_ready && !b_ready, "R9 stalled inputs", {a_ready, b_ready}, '0);

        // R8 and R6: single pair, floor of a small negative result
        cyc(1, 1, 1, {24'h0, 24'h1FFFFF}, {16'h0000, 16'h0001}, 1, 0);
        cyc(0, 0, 1, '0, '0, 0, 0);
        check(!y_valid, "R8 not yet after edge 1", y_valid, 0);
        cyc(0, 0, 1, '0, '0, 0, 0);
        check(!y_valid, "R8 not yet after edge 2", y_valid, 0);
        cyc(0, 0, 1, '0, '0, 0, 0);
        check(y_valid && y_data == 64'h00000000_FFFFFFFF && y_last,
              "R6 R8 floor result", {y_last, y_data}, {1'b1, 64'h00000000_FFFFFFFF});

        // R4 and R7: padding bits and b_last have no effect
        cyc(1, 1, 1, {3'b101, 21'h000003, 3'b111, 21'h000002}, {16'h4000, 16'h4000}, 0, 1);
        cyc(0, 0, 1, '0, '0, 0, 0);
        cyc(0, 0, 1, '0, '0, 0, 0);
        cyc(0, 0, 1, '0, '0, 0, 0);
        check(y_valid && y_data == model({24'h000003, 24'h000002}, {16'h4000, 16'h4000}) && !y_last,
              "R4 R7 padding and b_last", {y_last, y_data},
              {1'b0, model({24'h000003, 24'h000002}, {16'h4000, 16'h4000})});

        // R9 and R10: three back to back, then stall and resume
        cyc(1, 1, 1, {24'h010000, 24'h020000}, {16'h2000, 16'hE000}, 0, 0);
        cyc(1, 1, 1, {24'h1F0000, 24'h008000}, {16'h8000, 16'h7FFF}, 1, 0);
        cyc(1, 1, 1, {24'h100000, 24'h100000}, {16'h8000, 16'h8000}, 0, 0);
        cyc(0, 0, 0, '0, '0, 0, 0);
        held = y_data; held_last = y_last;
        cyc(0, 0, 0, '0, '0, 0, 0);
        cyc(0, 0, 0, '0, '0, 0, 0);
        check(y_valid && y_data == held && y_last == held_last, "R9 frozen output",
              {y_last, y_data}, {held_last, held});
        repeat (6) cyc(0, 0, 1, '0, '0, 0, 0);
        check(rp == wp, "R10 directed drain", 65'(rp), 65'(wp));

        // Random traffic with random backpressure
        for (int n = 0; n < 3000; n++) begin
            cyc(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 5) != 0,
                {rand_lane(), rand_lane()}, {rand_comp(), rand_comp()},
                1'($urandom), 1'($urandom));
        end
        repeat (8) cyc(0, 0, 1, '0, '0, 0, 0);
        check(rp == wp && wp > 100, "R10 random drain count", 65'(rp), 65'(wp));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule